// File: doc/BRIEF.md
# Graphics Port Grant Status Arbiter

This block sits on the target side of a point-to-point graphics bus. A single master shares the bus with the target. Each time the bus is free, the arbiter decides what the master may do next. It then raises a grant line and drives a 3-bit status code. The code tells the master one of four things: take back returned read or flush data, supply write data for a command it has already queued (low or high priority), or start a transaction of its own.

The inputs come from two places. The master supplies a bus request and a read-buffer-full flag. The target's internal queues supply four level-sensitive "pending" flags: low-priority read return, flush return, low-priority write and high-priority write. Once a code is issued, the grant is held and the code is frozen until a one-cycle completion strobe arrives from the data path. The grant then drops for one cycle before the next decision is made. A mode input selects active-high lines (fastest mode) or active-low lines (slower modes). It applies to the request, the read-buffer-full flag and the grant.

Top module: `gfx_grant_arbiter`

## Requirements
- R1: While reset is asserted and right after it, the grant is inactive and the status output reads 3'b111.
- R2: When the arbiter is idle, it picks in this priority order: high-priority write (status 3'b011), then low-priority write (3'b010), then read or flush returns, then a master start (3'b111) on request.
- R3: Between the returns, a pending low-priority read (3'b001) wins over a pending flush (3'b000).
- R4: While the read-buffer-full flag is asserted at the decision edge, no 3'b000 or 3'b001 grant is issued. Writes and master starts are still granted.
- R5: With nothing pending and no request, the grant stays inactive.
- R6: A grant, once issued, stays active with an unchanged status until a completion strobe is sampled. Changes on the pending flags, the request or the buffer flag have no effect during that time. A strobe sampled while idle has no effect.
- R7: The grant becomes inactive on the edge that samples the completion strobe. The next grant can appear at the earliest one edge later.
- R8: With mode=1, the request, buffer-full and grant lines are active high. With mode=0, all three are active low, so an undriven (high) buffer-full line reads as not full.
- R9: The codes 3'b100, 3'b101 and 3'b110 never appear while the grant is active.
- R10: While the grant is inactive, the status output reads 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_hi | input | 1 | 1: bus lines active high; 0: active low |
| req_line | input | 1 | Master bus request, polarity per mode_hi |
| rbf_line | input | 1 | Master read buffer full, polarity per mode_hi |
| rd_pend | input | 1 | Low-priority read return pending |
| fl_pend | input | 1 | Flush return pending |
| wr_lo_pend | input | 1 | Low-priority write command awaiting data |
| wr_hi_pend | input | 1 | High-priority write command awaiting data |
| xfer_done | input | 1 | One-cycle completion strobe for the current grant |
| gnt_line | output | 1 | Grant to master, polarity per mode_hi |
| st_code | output | 3 | Status code, meaningful while granted |

## Verification
The grant and code registers are the block's only state. A wrong value in either shows on gnt_line or st_code in the very cycle after the edge that produced it. A wrong priority, a missed buffer-full block or a premature release is therefore visible one edge after the decision or the strobe. A stuck or dropped hold shows as a code change or a missing release one cycle after the strobe. A polarity error shows at once on the grant line after the mode changes.

// File: rtl/gfx_arb_pkg.sv
package gfx_arb_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    ST_FLUSH = 3'b000,
    ST_READ  = 3'b001,
    ST_WR_LO = 3'b010,
    ST_WR_HI = 3'b011,
    ST_START = 3'b111
  } st_code_e;

  function automatic logic code_legal(input logic [CODE_W-1:0] c);
    return (c[2] == 1'b0) || (c == ST_START);
  endfunction
endpackage

// File: rtl/gfx_line_pol.sv
module gfx_line_pol #(
  parameter int N = 1
) (
  input  logic         mode_hi,
  input  logic [N-1:0] a,
  output logic [N-1:0] y
);
  // mode_hi=1 passes lines through, mode_hi=0 inverts them
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign y[i] = mode_hi ? a[i] : ~a[i];
  end
endmodule

// File: rtl/gfx_arb_pick.sv
module gfx_arb_pick
  import gfx_arb_pkg::*;
(
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              rd,
  input  logic              fl,
  input  logic              req,
  input  logic              rbf,
  output logic              pick_vld,
  output logic [CODE_W-1:0] pick_code
);
  logic rd_ok, fl_ok;

  assign rd_ok = rd & ~rbf;
  assign fl_ok = fl & ~rbf;

  always_comb begin
    pick_vld  = 1'b1;
    pick_code = ST_START;
    if (wr_hi)      pick_code = ST_WR_HI;
    else if (wr_lo) pick_code = ST_WR_LO;
    else if (rd_ok) pick_code = ST_READ;
    else if (fl_ok) pick_code = ST_FLUSH;
    else if (req)   pick_code = ST_START;
    else            pick_vld  = 1'b0;
  end

  always_comb begin
    if (pick_vld) assert_pick_legal_R9: assert (code_legal(pick_code));
    if (rbf && pick_vld)
      assert_pick_rbf_R4: assert (pick_code != ST_READ && pick_code != ST_FLUSH);
  end
endmodule

// File: rtl/gfx_arb_hold.sv
module gfx_arb_hold
  import gfx_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pick_vld,
  input  logic [CODE_W-1:0] pick_code,
  input  logic              done,
  output logic              gnt_q,
  output logic [CODE_W-1:0] code_q
);
  logic              gnt_d;
  logic [CODE_W-1:0] code_d;
  logic              upd_en;

  always_comb begin
    gnt_d  = gnt_q;
    code_d = code_q;
    upd_en = 1'b0;
    if (gnt_q) begin
      if (done) begin
        upd_en = 1'b1;
        gnt_d  = 1'b0;
        code_d = ST_START;
      end
    end else if (pick_vld) begin
      upd_en = 1'b1;
      gnt_d  = 1'b1;
      code_d = pick_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= 1'b0;
      code_q <= ST_START;
    end else if (upd_en) begin
      gnt_q  <= gnt_d;
      code_q <= code_d;
    end
  end

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q && !done) |=> (gnt_q && $stable(code_q)));
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q && done) |=> !gnt_q);
  assert_no_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_q |-> code_legal(code_q));
  assert_idle_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_q |-> (code_q == ST_START));
endmodule

// File: rtl/gfx_grant_arbiter.sv
module gfx_grant_arbiter
  import gfx_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_hi,
  input  logic              req_line,
  input  logic              rbf_line,
  input  logic              rd_pend,
  input  logic              fl_pend,
  input  logic              wr_lo_pend,
  input  logic              wr_hi_pend,
  input  logic              xfer_done,
  output logic              gnt_line,
  output logic [CODE_W-1:0] st_code
);
  logic [1:0]        in_int;
  logic              req_i, rbf_i;
  logic              pick_vld;
  logic [CODE_W-1:0] pick_code;
  logic              gnt_q;
  logic [CODE_W-1:0] code_q;

  gfx_line_pol #(.N(2)) u_in_pol (
    .mode_hi (mode_hi),
    .a       ({rbf_line, req_line}),
    .y       (in_int)
  );
  assign req_i = in_int[0];
  assign rbf_i = in_int[1];

  gfx_arb_pick u_pick (
    .wr_hi     (wr_hi_pend),
    .wr_lo     (wr_lo_pend),
    .rd        (rd_pend),
    .fl        (fl_pend),
    .req       (req_i),
    .rbf       (rbf_i),
    .pick_vld  (pick_vld),
    .pick_code (pick_code)
  );

  gfx_arb_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick_vld  (pick_vld),
    .pick_code (pick_code),
    .done      (xfer_done),
    .gnt_q     (gnt_q),
    .code_q    (code_q)
  );

  gfx_line_pol #(.N(1)) u_out_pol (
    .mode_hi (mode_hi),
    .a       (gnt_q),
    .y       (gnt_line)
  );
  assign st_code = code_q;

  assert_rbf_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gnt_q) && (code_q == ST_READ || code_q == ST_FLUSH)) |-> !$past(rbf_i));
  assert_write_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_q && wr_hi_pend) |=> (gnt_q && code_q == ST_WR_HI));
  assert_quiet_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_q && !wr_hi_pend && !wr_lo_pend && !rd_pend && !fl_pend && !req_i) |=> !gnt_q);
endmodule

// File: tb/gfx_grant_arbiter_bench.sv
module gfx_grant_arbiter_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_hi;
  logic b_req, b_rbf, b_rd, b_fl, b_lo, b_hi, b_done;
  logic req_line, rbf_line, gnt_line;
  logic [2:0] st_code;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  bit m_gnt;
  logic [2:0] m_code;
  bit prev_gnt;

  always #(CLK_P/2) clk = ~clk;

  assign req_line = mode_hi ? b_req : ~b_req;
  assign rbf_line = mode_hi ? b_rbf : ~b_rbf;

  gfx_grant_arbiter u_gfx_grant_arbiter (
    .clk(clk), .rst_n(rst_n), .mode_hi(mode_hi),
    .req_line(req_line), .rbf_line(rbf_line),
    .rd_pend(b_rd), .fl_pend(b_fl), .wr_lo_pend(b_lo), .wr_hi_pend(b_hi),
    .xfer_done(b_done), .gnt_line(gnt_line), .st_code(st_code)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model step at a clock edge
  task automatic model_step();
    if (!rst_n) begin
      m_gnt = 0; m_code = 3'b111;
    end else if (m_gnt) begin
      if (b_done) begin m_gnt = 0; m_code = 3'b111; end
    end else begin
      if (b_hi)                begin m_gnt = 1; m_code = 3'b011; end
      else if (b_lo)           begin m_gnt = 1; m_code = 3'b010; end
      else if (b_rd && !b_rbf) begin m_gnt = 1; m_code = 3'b001; end
      else if (b_fl && !b_rbf) begin m_gnt = 1; m_code = 3'b000; end
      else if (b_req)          begin m_gnt = 1; m_code = 3'b111; end
    end
  endtask

  task automatic cyc(input string tag);
    logic gnt_log;
    @(posedge clk);
    model_step();
    @(negedge clk);
    gnt_log = mode_hi ? gnt_line : ~gnt_line;
    check({tag, " grant/R8"}, {3'b000, gnt_line}, {3'b000, mode_hi ? m_gnt : ~m_gnt});
    check({tag, " status"}, {1'b0, st_code}, {1'b0, m_code});
    if (gnt_log) begin
      check("R9 no reserved code", {3'b000, (st_code inside {3'b100, 3'b101, 3'b110})}, 4'h0);
      if (!prev_gnt && st_code inside {3'b000, 3'b001})
        check("R4 return while full", {3'b000, b_rbf}, 4'h0);
    end else begin
      check("R10 idle status", {1'b0, st_code}, 4'h7);
    end
    prev_gnt = gnt_log;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic pulse_done(input string tag);
    b_done = 1; cyc(tag); b_done = 0;
  endtask

  task automatic set_pend(input logic hi, input logic lo, input logic rd,
                          input logic fl, input logic req, input logic rbf);
    b_hi = hi; b_lo = lo; b_rd = rd; b_fl = fl; b_req = req; b_rbf = rbf;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode_hi = 1; b_done = 0; prev_gnt = 0;
    set_pend(0, 0, 0, 0, 0, 0);
    m_gnt = 0; m_code = 3'b111;
    // R1: reset state, even with everything pending
    set_pend(1, 1, 1, 1, 1, 0);
    run(3, "R1");
    check("R1 reset grant", {3'b000, gnt_line}, 4'h0);
    check("R1 reset status", {1'b0, st_code}, 4'h7);
    set_pend(0, 0, 0, 0, 0, 0);
    rst_n = 1;
    run(2, "R1");

    // R5: nothing pending, no request
    run(4, "R5");
    b_req = 1; cyc("R5"); run(2, "R6");
    b_req = 0; pulse_done("R7"); run(2, "R7");

    // R2: priority chain, queues drain after each completion
    set_pend(1, 1, 1, 1, 1, 0);
    cyc("R2"); run(2, "R6");
    b_hi = 0; pulse_done("R7"); cyc("R2"); cyc("R2");
    b_lo = 0; pulse_done("R7"); cyc("R3"); cyc("R3");
    b_rd = 0; pulse_done("R7"); cyc("R3"); cyc("R3");
    b_fl = 0; pulse_done("R7"); cyc("R2"); cyc("R2");
    b_req = 0; pulse_done("R7"); run(2, "R5");

    // R6: inputs change during a grant, strobe while idle ignored
    set_pend(0, 0, 1, 0, 0, 0);
    cyc("R6");
    set_pend(1, 1, 0, 1, 1, 1); run(3, "R6");
    set_pend(0, 0, 0, 0, 0, 0); pulse_done("R6");
    b_done = 1; run(3, "R6"); b_done = 0; run(1, "R6");

    // R4: buffer full blocks returns only
    set_pend(0, 0, 1, 1, 0, 1); run(3, "R4");
    b_req = 1; cyc("R4"); b_req = 0; pulse_done("R4"); run(1, "R4");
    b_lo = 1; cyc("R4"); b_lo = 0; pulse_done("R4"); run(2, "R4");
    b_rbf = 0; cyc("R4"); run(1, "R4");
    set_pend(0, 0, 0, 0, 0, 0); pulse_done("R4"); run(1, "R4");

    // R8: active-low lines
    mode_hi = 0; run(2, "R8");
    set_pend(0, 0, 1, 0, 1, 1); cyc("R8"); run(1, "R8");
    b_req = 0; pulse_done("R8"); run(1, "R8");
    b_rbf = 0; cyc("R8"); b_rd = 0; pulse_done("R8"); run(2, "R8");

    // mixed traffic in both modes
    for (int k = 0; k < 3000; k++) begin
      if (k % 500 == 0 && !m_gnt) mode_hi = ~mode_hi;
      b_hi  = ($urandom % 6) == 0;
      b_lo  = ($urandom % 5) == 0;
      b_rd  = ($urandom % 3) == 0;
      b_fl  = ($urandom % 4) == 0;
      b_req = ($urandom % 3) == 0;
      b_rbf = ($urandom % 2) == 0;
      b_done = ($urandom % 3) == 0;
      cyc("R2");
    end
    b_done = 0;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule